// File: doc/BRIEF.md
# Host Interrupt Status and Mask Unit

This unit gathers single-cycle event pulses from the device side of a storage controller and turns them into interrupts for the host. There are nine event sources: a firmware state change, a posted completion, a message from the device, a full flag for each of four command queues, a command FIFO overrun, and a bad expansion-ROM read. Each pulse sets a sticky bit in a status register. The host clears a bit by writing 1 to it.

A mask register with the same bit layout suppresses individual sources, and a global enable bit in a control register gates a single level-sensitive interrupt line. Independently of that enable, the unit presents a message code for message-signalled interrupts. The code belongs to the lowest-numbered unmasked pending source. The host reaches all registers through a plain 32-bit register port with single-cycle writes and combinational reads.

Top module: `irq_hub`

## Requirements
- R1: After reset, status, mask and enable read as zero, `irq_o` is low and `msg_vld` is low.
- R2: A pulse on `evt_in[b]` sets status bit b at offset 0x520 on the next clock edge, and the bit stays set until it is cleared. The bit map is: 0 firmware state change, 1 completion posted, 2 message from device, 5 to 8 queue 0 to 3 full, 9 command FIFO overrun, 10 bad expansion-ROM read.
- R3: Writing to offset 0x520 clears every status bit whose write-data bit is 1. Bits written as 0 keep their value.
- R4: Status bits 3, 4 and 11 to 31 never set and always read as zero, even when `evt_in[3]` or `evt_in[4]` pulse.
- R5: The mask register at offset 0x528 stores the nine mapped bits of a write and reads back 0x7E7 after all ones are written. Its reserved bits read as zero.
- R6: Bit 7 of the control register at offset 0x500 is the global enable. All other control bits read as zero.
- R7: `irq_o` is high exactly when the enable is set and at least one status bit is set whose mask bit is 0.
- R8: If an event pulse and a write-1-to-clear hit the same status bit in the same cycle, the bit stays set.
- R9: `msg_vld` is high when an unmasked pending source that has a code exists. `msg_code` is then the code of the lowest-numbered such bit: bit 0 gives 4, bit 1 gives 5, bit 2 gives 6, bits 5 to 8 give 9 to 12. Bits 9 and 10 carry no code. The code does not depend on the enable.
- R10: Reads of any other offset return zero, and writes to any other offset change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| reg_addr | input | 12 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| evt_in | input | 11 | Event pulses, aligned with the status bit map |
| irq_o | output | 1 | Level interrupt to the host |
| msg_vld | output | 1 | A message code is available |
| msg_code | output | 8 | Message code of the highest-priority pending source |

## Verification
On every cycle, the assertions check four things. Events always land in status. A clear write removes exactly the bits it names unless an event hits the same bit. The interrupt line never rises without the enable and an unmasked pending bit. Reserved status bits always read as zero. Only the bench scenarios can show the full source-to-bit and source-to-code map, the priority among several pending sources as masks change, the read-back values of mask and control, and the fact that writes to unmapped offsets have no effect.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int NSRC = 11;
  localparam logic [NSRC-1:0] LIVE_BITS  = 11'h7E7;
  localparam logic [NSRC-1:0] CODED_BITS = 11'h1E7;
  localparam int OFF_CTRL = 'h500;
  localparam int OFF_STAT = 'h520;
  localparam int OFF_MASK = 'h528;
  localparam int EN_BIT   = 7;
  localparam int CODE_W   = 8;

  function automatic logic [CODE_W-1:0] src_code(input int b);
    case (b)
      0: src_code = 8'd4;
      1: src_code = 8'd5;
      2: src_code = 8'd6;
      5: src_code = 8'd9;
      6: src_code = 8'd10;
      7: src_code = 8'd11;
      8: src_code = 8'd12;
      default: src_code = 8'd0;
    endcase
  endfunction
endpackage

// File: rtl/irq_hub_status.sv
module irq_hub_status
  import irq_hub_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] status
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    if (LIVE_BITS[i]) begin : g_live
      logic q, nxt, upd;
      always_comb begin
        upd = evt[i] | clr[i];
        nxt = evt[i] | (q & ~clr[i]);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= 1'b0;
        else if (upd) q <= nxt;
      end
      assign status[i] = q;
    end else begin : g_hole
      assign status[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_hub_prio.sv
module irq_hub_prio
  import irq_hub_pkg::*;
(
  input  logic [NSRC-1:0]   pend,
  output logic              vld,
  output logic [CODE_W-1:0] code
);
  always_comb begin
    vld  = 1'b0;
    code = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i] && CODED_BITS[i]) begin
        vld  = 1'b1;
        code = src_code(i);
      end
    end
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NSRC-1:0]   evt_in,
  output logic              irq_o,
  output logic              msg_vld,
  output logic [CODE_W-1:0] msg_code
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFF_MASK);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic            wr_ctrl, wr_stat, wr_mask;
  logic [NSRC-1:0] clr_vec, status_q, mask_q, mask_nxt, pend;
  logic            en_q, en_nxt;

  always_comb begin
    wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
    wr_stat  = reg_wr && (reg_addr == A_STAT);
    wr_mask  = reg_wr && (reg_addr == A_MASK);
    clr_vec  = wr_stat ? reg_wdata[NSRC-1:0] : '0;
    mask_nxt = reg_wdata[NSRC-1:0] & LIVE_BITS;
    en_nxt   = reg_wdata[EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  mask_q <= '0;
    else if (wr_mask) mask_q <= mask_nxt;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  en_q <= 1'b0;
    else if (wr_ctrl) en_q <= en_nxt;
  end

  irq_hub_status u_stat (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .evt    (evt_in),
    .clr    (clr_vec),
    .status (status_q)
  );

  assign pend  = status_q & ~mask_q;
  assign irq_o = en_q & (|pend);

  irq_hub_prio u_prio (
    .pend (pend),
    .vld  (msg_vld),
    .code (msg_code)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata[EN_BIT]   = en_q;
      A_STAT:  reg_rdata[NSRC-1:0] = status_q;
      A_MASK:  reg_rdata[NSRC-1:0] = mask_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
  import irq_hub_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [NSRC-1:0]   evt_in,
  input logic              irq_o,
  input logic              msg_vld,
  input logic [NSRC-1:0]   status_q,
  input logic [NSRC-1:0]   mask_q,
  input logic              en_q
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);

  // R2 and R8: an event always lands, even against a clear
  assert_evt_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(evt_in & LIVE_BITS)) == $past(evt_in & LIVE_BITS)));

  // R3: clear removes the named bits that no event hits
  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_STAT) |=>
      ((status_q & $past(reg_wdata[NSRC-1:0] & ~evt_in)) == '0));

  // R3: bits untouched by write and event hold
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && evt_in == '0) |=> $stable(status_q));

  // R4: reserved status bits read as zero
  assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_STAT) |-> (reg_rdata[4:3] == 2'b00 && reg_rdata[DATA_W-1:NSRC] == '0));

  // R7: no interrupt without enable and an unmasked pending bit
  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (en_q && (status_q & ~mask_q) != '0));

  // R9: a message code needs an unmasked pending coded source
  assert_msg_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_vld |-> ((status_q & ~mask_q & CODED_BITS) != '0));
endmodule

bind irq_hub irq_hub_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .evt_in    (evt_in),
  .irq_o     (irq_o),
  .msg_vld   (msg_vld),
  .status_q  (status_q),
  .mask_q    (mask_q),
  .en_q      (en_q)
);

// File: tb/irq_hub_test.sv
module irq_hub_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [10:0] evt_in;
  logic        irq_o;
  logic        msg_vld;
  logic [7:0]  msg_code;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  irq_hub uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
    .irq_o(irq_o), .msg_vld(msg_vld), .msg_code(msg_code)
  );

  localparam logic [11:0] CTRL = 12'h500, STAT = 12'h520, MASK = 12'h528;

  function automatic logic [7:0] exp_code(input int b);
    if (b <= 2)                 return 8'(4 + b);
    else if (b >= 5 && b <= 8)  return 8'(4 + b);
    else                        return 8'd0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic [10:0] e);
    @(negedge clk);
    evt_in = e;
    @(negedge clk);
    evt_in = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(CTRL, d); chk("R1 ctrl", d, 0);
    rd(STAT, d); chk("R1 status", d, 0);
    rd(MASK, d); chk("R1 mask", d, 0);
    chk("R1 irq", {31'd0, irq_o}, 0);
    chk("R1 msg_vld", {31'd0, msg_vld}, 0);
  endtask

  task automatic t_map;
    logic [31:0] d;
    for (int b = 0; b < 11; b++) begin
      if (b == 3 || b == 4) continue;
      pulse(11'(1 << b));
      rd(STAT, d); chk("R2 map", d, 32'(1 << b));
      wr(STAT, 32'(1 << b));
      rd(STAT, d); chk("R3 clear", d, 0);
    end
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    pulse(11'b000_0001_1000);
    rd(STAT, d); chk("R4 reserved", d, 0);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    pulse(11'h221);
    wr(STAT, 32'h0);
    rd(STAT, d); chk("R3 write0", d, 32'h221);
    wr(STAT, 32'h20);
    rd(STAT, d); chk("R3 partial", d, 32'h201);
    wr(STAT, 32'hFFFF_FFFF);
    rd(STAT, d); chk("R3 all", d, 0);
  endtask

  task automatic t_mask_ctrl;
    logic [31:0] d;
    wr(MASK, 32'hFFFF_FFFF);
    rd(MASK, d); chk("R5 mask readback", d, 32'h7E7);
    wr(MASK, 32'h0);
    wr(CTRL, 32'hFFFF_FFFF);
    rd(CTRL, d); chk("R6 ctrl readback", d, 32'h80);
  endtask

  task automatic t_irq;
    pulse(11'h002);
    #1 chk("R7 irq on", {31'd0, irq_o}, 1);
    wr(MASK, 32'h002);
    #1 chk("R7 masked", {31'd0, irq_o}, 0);
    wr(MASK, 32'h0);
    wr(CTRL, 32'h0);
    #1 chk("R7 disabled", {31'd0, irq_o}, 0);
    chk("R9 code w/o enable", {23'd0, msg_vld, msg_code}, {23'd0, 1'b1, 8'd5});
    wr(CTRL, 32'h80);
    #1 chk("R7 re-enabled", {31'd0, irq_o}, 1);
    wr(STAT, 32'h7FF);
    #1 chk("R7 cleared", {31'd0, irq_o}, 0);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    pulse(11'h004);
    @(negedge clk);
    reg_addr = STAT; reg_wdata = 32'h4; reg_wr = 1'b1; evt_in = 11'h004;
    @(negedge clk);
    reg_wr = 1'b0; evt_in = '0;
    rd(STAT, d); chk("R8 collide", d, 32'h4);
    wr(STAT, 32'h4);
  endtask

  task automatic t_prio;
    logic [31:0] d;
    for (int b = 0; b < 9; b++) begin
      if (b == 3 || b == 4) continue;
      pulse(11'(1 << b));
      #1 chk("R9 single code", {23'd0, msg_vld, msg_code}, {23'd0, 1'b1, exp_code(b)});
      wr(STAT, 32'(1 << b));
    end
    pulse(11'h242);
    #1 chk("R9 lowest", {24'd0, msg_code}, 32'd5);
    wr(MASK, 32'h002);
    #1 chk("R9 next", {24'd0, msg_code}, 32'd10);
    wr(MASK, 32'h042);
    #1 chk("R9 uncoded only", {31'd0, msg_vld}, 0);
    chk("R7 overrun irq", {31'd0, irq_o}, 1);
    wr(MASK, 32'h0);
    wr(STAT, 32'h7FF);
    rd(STAT, d); chk("R3 final clear", d, 0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(MASK, 32'h3);
    pulse(11'h001);
    wr(12'h530, 32'hFFFF_FFFF);
    wr(12'h524, 32'hFFFF_FFFF);
    rd(12'h524, d); chk("R10 read hole", d, 0);
    rd(12'h504, d); chk("R10 read hole2", d, 0);
    rd(STAT, d); chk("R10 status kept", d, 32'h1);
    rd(MASK, d); chk("R10 mask kept", d, 32'h3);
    rd(CTRL, d); chk("R10 ctrl kept", d, 32'h80);
  endtask

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0; evt_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_map();
    t_reserved();
    t_w1c();
    t_mask_ctrl();
    t_irq();
    t_collide();
    t_prio();
    t_unmapped();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule